// File: doc/BRIEF.md
# Flag Offset Register Loader

This block keeps the two threshold values that a FIFO's almost-empty and almost-full flag logic compares against: an empty-side offset and a full-side offset. Each offset is wider than the data bus, so it is held as a group of bus-wide bytes. The flag comparison itself lives elsewhere and simply reads `empty_ofs` and `full_ofs`.

Two load methods exist, and the method is fixed when master reset is applied. In byte mode, each `wr_stb` pulse writes `wr_data` into the next byte slot. In bit mode, each clock with `ser_en` high writes `ser_bit` into the next bit slot. Master reset also loads both offsets with one of two preset values, chosen by `cfg_dflt_sel`. The stored bytes can be read back through `rd_stb` and `rd_data` at any time, whichever load method is active. A partial reset of the surrounding FIFO leaves all of this state untouched.

Top module: `flag_ofs_loader`

## Requirements
- R1: A clock edge with `mrst` high loads both offsets with the same preset. The preset is 0x07F (zero-extended) when `cfg_dflt_sel` is 0 and 0x0FF when it is 1. The same edge returns the byte write slot, the bit write slot and the read slot to their first position, and clears `rd_data` to 0.
- R2: The load method is taken from `cfg_serial` only at an edge with `mrst` high: 0 selects byte mode and 1 selects bit mode. Changing `cfg_serial` at any other time has no effect.
- R3: In byte mode, each edge with `wr_stb` high writes `wr_data` into the current byte slot. The slots are taken in this order: empty-offset bytes from least significant to most significant, then full-offset bytes in the same order. After the last full-offset byte, the next write goes to the first empty-offset byte. Bits of the top byte that lie above the offset width are discarded.
- R4: In byte mode, `ser_en` and `ser_bit` have no effect on the offsets.
- R5: In bit mode, each edge with `ser_en` high writes `ser_bit` into the current bit slot. The slots are taken in this order: empty-offset bits 0 upward, then full-offset bits 0 upward. After the last full-offset bit, the next write goes to empty-offset bit 0.
- R6: In bit mode, `wr_stb` and `wr_data` have no effect on the offsets.
- R7: In both modes, each edge with `rd_stb` high presents the current read slot's byte on `rd_data` from that edge onward. Read slots follow the same order as R3 and have their own wrapping position. Bits of the top byte that lie above the offset width read as 0.
- R8: `prst` has no effect on the offsets, on the write and read slot positions, or on the load method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Partial reset of the surrounding FIFO; leaves this block unchanged |
| cfg_serial | input | 1 | Load method sampled at master reset (1 = bit mode) |
| cfg_dflt_sel | input | 1 | Preset choice sampled at master reset (1 = 0x0FF) |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to write |
| ser_en | input | 1 | Bit write enable |
| ser_bit | input | 1 | Bit to write |
| rd_stb | input | 1 | Byte read strobe |
| rd_data | output | DATA_W | Byte read back |
| empty_ofs | output | OFFSET_W | Empty-side offset |
| full_ofs | output | OFFSET_W | Full-side offset |

## Verification
The hardest state to reach from the ports is the wrap point of each slot sequence. Reaching it takes six byte writes, or 38 bit writes, before the next write lands back on the empty offset. The bench drives both sequences past a full cycle and checks the offsets after every single write, so an off-by-one at the wrap or in the bit order shows up at the exact write that causes it. The bench also changes `cfg_serial` and pulses `prst` in the middle of a sequence. It then checks that the next byte still lands in the slot it predicts and that the next read still comes from the slot it predicts.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

    typedef enum logic {
        LOAD_BYTE = 1'b0,
        LOAD_BIT  = 1'b1
    } load_mode_e;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned idx_width(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/ofl_wrap_ctr.sv
module ofl_wrap_ctr #(
    parameter int unsigned COUNT = 6,
    localparam int unsigned CW   = ofl_pkg::idx_width(COUNT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (adv)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // R3 R5 R7
    ctr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && cnt_q == LAST) |=> (cnt_q == '0));

    // R8
    ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/ofl_store.sv
module ofl_store #(
    parameter int unsigned DATA_W   = 9,
    parameter int unsigned OFFSET_W = 19,
    parameter logic [DATA_W-1:0] DFLT_LO = DATA_W'('h7F),
    parameter logic [DATA_W-1:0] DFLT_HI = DATA_W'('hFF),
    localparam int unsigned NB   = ofl_pkg::ceil_div(OFFSET_W, DATA_W),
    localparam int unsigned BW   = ofl_pkg::idx_width(2 * NB),
    localparam int unsigned SW   = ofl_pkg::idx_width(2 * OFFSET_W)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dflt_sel,
    input  logic                byte_we,
    input  logic [BW-1:0]       byte_sel,
    input  logic [DATA_W-1:0]   byte_data,
    input  logic                bit_we,
    input  logic [SW-1:0]       bit_sel,
    input  logic                bit_val,
    input  logic [BW-1:0]       rd_sel,
    output logic [DATA_W-1:0]   rd_byte_o,
    output logic [OFFSET_W-1:0] empty_o,
    output logic [OFFSET_W-1:0] full_o
);
    localparam int unsigned PADW = NB * DATA_W;
    localparam logic [BW-1:0] NB_L = BW'(NB);
    localparam logic [SW-1:0] OW_L = SW'(OFFSET_W);
    localparam logic [PADW-1:0] BYTE_MASK = PADW'({DATA_W{1'b1}});

    typedef struct packed {
        logic [OFFSET_W-1:0] full;
        logic [OFFSET_W-1:0] empty;
    } ofs_pair_t;

    ofs_pair_t ofs_q, ofs_d;

    function automatic logic [OFFSET_W-1:0] splice_byte(
        input logic [OFFSET_W-1:0] old_v,
        input logic [BW-1:0]       k,
        input logic [DATA_W-1:0]   d
    );
        logic [PADW-1:0] pad;
        int unsigned     sh;
        sh  = int'(k) * DATA_W;
        pad = PADW'(old_v);
        pad = (pad & ~(BYTE_MASK << sh)) | (PADW'(d) << sh);
        return pad[OFFSET_W-1:0];
    endfunction

    function automatic logic [OFFSET_W-1:0] splice_bit(
        input logic [OFFSET_W-1:0] old_v,
        input logic [SW-1:0]       p,
        input logic                b
    );
        logic [OFFSET_W-1:0] one;
        one = OFFSET_W'(1);
        return (old_v & ~(one << p)) | (OFFSET_W'(b) << p);
    endfunction

    logic          byte_hi, bit_hi, rd_hi;
    logic [BW-1:0] byte_k, rd_k;
    logic [SW-1:0] bit_p;

    assign byte_hi = (byte_sel >= NB_L);
    assign byte_k  = byte_hi ? byte_sel - NB_L : byte_sel;
    assign bit_hi  = (bit_sel >= OW_L);
    assign bit_p   = bit_hi ? bit_sel - OW_L : bit_sel;
    assign rd_hi   = (rd_sel >= NB_L);
    assign rd_k    = rd_hi ? rd_sel - NB_L : rd_sel;

    always_comb begin
        ofs_d = ofs_q;
        if (byte_we) begin
            if (byte_hi) ofs_d.full  = splice_byte(ofs_q.full,  byte_k, byte_data);
            else         ofs_d.empty = splice_byte(ofs_q.empty, byte_k, byte_data);
        end else if (bit_we) begin
            if (bit_hi)  ofs_d.full  = splice_bit(ofs_q.full,  bit_p, bit_val);
            else         ofs_d.empty = splice_bit(ofs_q.empty, bit_p, bit_val);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs_q.empty <= OFFSET_W'(dflt_sel ? DFLT_HI : DFLT_LO);
            ofs_q.full  <= OFFSET_W'(dflt_sel ? DFLT_HI : DFLT_LO);
        end else begin
            ofs_q <= ofs_d;
        end
    end

    logic [PADW-1:0] rd_pad;
    assign rd_pad    = PADW'(rd_hi ? ofs_q.full : ofs_q.empty) >> (int'(rd_k) * DATA_W);
    assign rd_byte_o = rd_pad[DATA_W-1:0];

    assign empty_o = ofs_q.empty;
    assign full_o  = ofs_q.full;

    // R5
    one_bit_per_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_we && !byte_we) |=> ($countones(ofs_q ^ $past(ofs_q)) <= 1));

    // R3
    one_side_per_byte_chk: assert property (@(posedge clk) disable iff (rst)
        byte_we |=> ($stable(ofs_q.empty) || $stable(ofs_q.full)));

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader #(
    parameter int unsigned DATA_W   = 9,
    parameter int unsigned OFFSET_W = 19,
    parameter logic [DATA_W-1:0] DFLT_LO = DATA_W'('h7F),
    parameter logic [DATA_W-1:0] DFLT_HI = DATA_W'('hFF)
) (
    input  logic                clk,
    input  logic                mrst,
    input  logic                prst,
    input  logic                cfg_serial,
    input  logic                cfg_dflt_sel,
    input  logic                wr_stb,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ser_en,
    input  logic                ser_bit,
    input  logic                rd_stb,
    output logic [DATA_W-1:0]   rd_data,
    output logic [OFFSET_W-1:0] empty_ofs,
    output logic [OFFSET_W-1:0] full_ofs
);
    import ofl_pkg::*;

    localparam int unsigned NB     = ceil_div(OFFSET_W, DATA_W);
    localparam int unsigned NSLOT  = 2 * NB;
    localparam int unsigned NBIT   = 2 * OFFSET_W;
    localparam int unsigned BW     = idx_width(NSLOT);
    localparam int unsigned SW     = idx_width(NBIT);

    load_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (mrst) mode_q <= load_mode_e'(cfg_serial);
    end

    logic byte_we, bit_we;
    assign byte_we = !mrst && (mode_q == LOAD_BYTE) && wr_stb;
    assign bit_we  = !mrst && (mode_q == LOAD_BIT)  && ser_en;

    logic [BW-1:0] wr_slot, rd_slot;
    logic [SW-1:0] bit_slot;

    ofl_wrap_ctr #(.COUNT(NSLOT)) u_wr_slot (
        .clk(clk), .rst(mrst), .adv(byte_we), .cnt_o(wr_slot)
    );

    ofl_wrap_ctr #(.COUNT(NSLOT)) u_rd_slot (
        .clk(clk), .rst(mrst), .adv(rd_stb), .cnt_o(rd_slot)
    );

    ofl_wrap_ctr #(.COUNT(NBIT)) u_bit_slot (
        .clk(clk), .rst(mrst), .adv(bit_we), .cnt_o(bit_slot)
    );

    logic [DATA_W-1:0] rd_byte;

    ofl_store #(
        .DATA_W(DATA_W), .OFFSET_W(OFFSET_W),
        .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)
    ) u_store (
        .clk       (clk),
        .rst       (mrst),
        .dflt_sel  (cfg_dflt_sel),
        .byte_we   (byte_we),
        .byte_sel  (wr_slot),
        .byte_data (wr_data),
        .bit_we    (bit_we),
        .bit_sel   (bit_slot),
        .bit_val   (ser_bit),
        .rd_sel    (rd_slot),
        .rd_byte_o (rd_byte),
        .empty_o   (empty_ofs),
        .full_o    (full_ofs)
    );

    always_ff @(posedge clk) begin
        if (mrst)        rd_data <= '0;
        else if (rd_stb) rd_data <= rd_byte;
    end

    // R1
    preset_load_chk: assert property (@(posedge clk)
        mrst |=> (empty_ofs == OFFSET_W'($past(cfg_dflt_sel) ? DFLT_HI : DFLT_LO)
               && full_ofs  == OFFSET_W'($past(cfg_dflt_sel) ? DFLT_HI : DFLT_LO)
               && rd_data == '0));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> $stable(mode_q));

    // R4
    byte_mode_bits_ignored_chk: assert property (@(posedge clk) disable iff (mrst)
        (mode_q == LOAD_BYTE && !wr_stb) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R6
    bit_mode_bytes_ignored_chk: assert property (@(posedge clk) disable iff (mrst)
        (mode_q == LOAD_BIT && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R8
    prst_no_effect_chk: assert property (@(posedge clk) disable iff (mrst)
        (prst && !wr_stb && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)
                                          && $stable(mode_q)));

endmodule

// File: tb/flag_ofs_loader_tb_top.sv
module flag_ofs_loader_tb_top;

    localparam int CLK_P  = 10;
    localparam int DW     = 9;
    localparam int OW     = 19;
    localparam int NB     = 3;
    localparam int NSLOT  = 2 * NB;
    localparam int NBIT   = 2 * OW;
    localparam int WD_LIM = 20000;

    logic          clk = 1'b0;
    logic          mrst = 1'b1, prst = 1'b0;
    logic          cfg_serial = 1'b0, cfg_dflt_sel = 1'b0;
    logic          wr_stb = 1'b0, ser_en = 1'b0, ser_bit = 1'b0, rd_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [OW-1:0] empty_ofs, full_ofs;

    always #(CLK_P / 2) clk = ~clk;

    flag_ofs_loader #(.DATA_W(DW), .OFFSET_W(OW)) dut_i (
        .clk(clk), .mrst(mrst), .prst(prst),
        .cfg_serial(cfg_serial), .cfg_dflt_sel(cfg_dflt_sel),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .ser_en(ser_en), .ser_bit(ser_bit),
        .rd_stb(rd_stb), .rd_data(rd_data),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    int n_run = 0, n_fail = 0;
    logic [OW-1:0] m_e, m_f;
    logic          m_ser;
    int            m_wp, m_rp, m_bp;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_byte(input int slot);
        logic [NB*DW-1:0] pad;
        pad = (NB*DW)'((slot < NB) ? m_e : m_f);
        return DW'(pad >> ((slot % NB) * DW));
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic ser, input logic sel);
        cfg_serial = ser; cfg_dflt_sel = sel; mrst = 1'b1;
        tick;
        mrst = 1'b0;
        m_ser = ser;
        m_e = OW'(sel ? 9'h0FF : 9'h07F);
        m_f = m_e;
        m_wp = 0; m_rp = 0; m_bp = 0;
        chk("R1 empty preset", 32'(empty_ofs), 32'(m_e));
        chk("R1 full preset",  32'(full_ofs),  32'(m_f));
        chk("R1 rd_data clear", 32'(rd_data), 32'd0);
    endtask

    task automatic byte_wr(input logic [DW-1:0] d);
        logic [NB*DW-1:0] pad;
        int sh;
        wr_stb = 1'b1; wr_data = d;
        tick;
        wr_stb = 1'b0;
        if (!m_ser) begin
            sh  = (m_wp % NB) * DW;
            pad = (NB*DW)'((m_wp < NB) ? m_e : m_f);
            pad = (pad & ~((NB*DW)'(9'h1FF) << sh)) | ((NB*DW)'(d) << sh);
            if (m_wp < NB) m_e = OW'(pad); else m_f = OW'(pad);
            m_wp = (m_wp + 1) % NSLOT;
        end
    endtask

    task automatic bit_wr(input logic b);
        ser_en = 1'b1; ser_bit = b;
        tick;
        ser_en = 1'b0;
        if (m_ser) begin
            if (m_bp < OW) m_e[m_bp] = b; else m_f[m_bp - OW] = b;
            m_bp = (m_bp + 1) % NBIT;
        end
    endtask

    task automatic rd_chk(input string req);
        rd_stb = 1'b1;
        tick;
        rd_stb = 1'b0;
        chk(req, 32'(rd_data), 32'(model_byte(m_rp)));
        m_rp = (m_rp + 1) % NSLOT;
    endtask

    task automatic ofs_chk(input string req);
        chk(req, 32'(empty_ofs), 32'(m_e));
        chk(req, 32'(full_ofs),  32'(m_f));
    endtask

    initial begin
        repeat (WD_LIM) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: both presets, read back through the read slots (R7)
        do_reset(1'b0, 1'b0);
        for (int i = 0; i < NSLOT; i++) rd_chk("R7 preset 7F readback");
        do_reset(1'b0, 1'b1);
        for (int i = 0; i < NSLOT; i++) rd_chk("R7 preset FF readback");

        // R3: byte writes across a full cycle and past the wrap
        for (int i = 0; i < NSLOT + 2; i++) begin
            byte_wr(DW'((i * 37 + 5) % 512));
            ofs_chk("R3 byte slot order");
        end
        for (int i = 0; i < NSLOT; i++) rd_chk("R7 byte mode readback");

        // R4: bit strobes ignored in byte mode
        for (int i = 0; i < 5; i++) bit_wr(i[0]);
        ofs_chk("R4 ser_en ignored");

        // R8: prst keeps offsets and slot positions
        prst = 1'b1; tick; tick; prst = 1'b0;
        ofs_chk("R8 prst offsets kept");
        byte_wr(9'h155);
        ofs_chk("R8 write slot kept");
        rd_chk("R8 read slot kept");

        // R2: cfg_serial change without mrst leaves byte mode in place
        cfg_serial = 1'b1;
        tick;
        for (int i = 0; i < 4; i++) bit_wr(1'b1);
        ofs_chk("R2 mode not re-sampled");
        byte_wr(9'h0A3);
        ofs_chk("R2 still byte mode");

        // Bit mode
        do_reset(1'b1, 1'b0);
        // R6: byte strobes ignored in bit mode
        for (int i = 0; i < 3; i++) byte_wr(9'h1C0);
        ofs_chk("R6 wr_stb ignored");
        // R5: two full passes through the bit slots, covering the wrap
        for (int i = 0; i < 2 * NBIT + 3; i++) begin
            bit_wr(((i * 5 + i / 7) % 3) == 0);
            ofs_chk("R5 bit slot order");
        end
        for (int i = 0; i < NSLOT + 1; i++) rd_chk("R7 bit mode readback");

        // R8 in bit mode
        prst = 1'b1; tick; prst = 1'b0;
        bit_wr(1'b1);
        ofs_chk("R8 bit slot kept");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule